// File: doc/BRIEF.md
# Serial Byte Transmitter with Completion Flags

This block turns bytes written by a processor into asynchronous serial frames on a single output line. Software sets up the bit rate, the character size, parity and the stop-bit count through a small register file on a byte-wide write bus, then writes characters to a data register. Each character goes out as one frame: a low start bit, 5 to 9 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Between frames the line is held high.

Two status flags let software pace itself. The empty flag tells software that the data register can take the next character. The complete flag tells software that the line has gone quiet. Each flag has an enable bit and its own level interrupt output. A character written while a frame is on the line waits in a one-entry holding slot. It goes out with no idle gap once the current frame's last stop bit ends.

Register addresses: 0 data, 1 status, 2 control, 3 format, 4 divisor low byte, 5 divisor high byte. Reads have no side effects.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset the line is high, status reads 0x01 (empty flag = bit 0 set, complete flag = bit 1 clear), and both interrupt outputs are low.
- R2: One bit lasts (D+1)*16 clock cycles, or (D+1)*8 when control bit 3 (double speed) is set. D is the 16-bit divisor made of registers 4 (low) and 5 (high). Writing either divisor byte restarts the bit timer with the new value.
- R3: A frame starts at the clock edge that accepts the data write. It sends a low start bit, then the data bits LSB first, then the parity bit (if any), then the stop bits, which are high. The line is high whenever no frame is active.
- R4: Format register bits 2:0 set the character size: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits; codes 4, 5 and 6 give 8 bits; code 7 gives 9 bits. In the 9-bit case the ninth bit is control bit 7.
- R5: Control bits 6:5 set parity. 00 and 01 send no parity bit. 10 sends even parity and 11 sends odd parity, each taken over the data bits that are sent.
- R6: The number of stop bits is 1 plus control bit 4.
- R7: A data write clears the empty flag. When a frame ends with nothing waiting, the empty and complete flags are both set, but only if control bit 0 (transmit enable) is 1. With bit 0 clear the frame is still sent and both flags stay unchanged.
- R8: A data write during an active frame is held and sent right after the current frame, with no idle bit between them. The flags are set only at the end of the last frame.
- R9: Writing status with bit 1 = 1 clears the complete flag. No other bit of a status write has any effect, and writing bit 1 = 0 leaves the flag unchanged.
- R10: A control write that takes bit 1 (empty interrupt enable) from 0 to 1 while no frame is active or waiting sets the empty flag. The same change during a transmission does not.
- R11: The empty interrupt output is the empty flag AND control bit 1. The complete interrupt output is the complete flag AND control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| txd | output | 1 | Serial output line |
| irq_empty | output | 1 | Empty interrupt request (level) |
| irq_done | output | 1 | Complete interrupt request (level) |

## Verification
Register and flag effects show up after the clock edge that accepts the write. Bit k of a frame started by a write at edge E occupies edges E+k·B through E+(k+1)·B, where B is the bit period. The flags change at edge E+len·B. The bench counts clock edges and samples the line at the negedge halfway through each bit. It reads the status one cycle before the frame boundary and again right on it, so a frame that ends one cycle early or late is caught. The interrupt outputs are checked at the negedge that directly follows the control write.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int ADDR_W  = 3;
    localparam int DIV_W   = 16;
    localparam int MAXDATA = 9;
    localparam int FRAME_W = 1 + MAXDATA + 1 + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [ADDR_W-1:0] {
        A_DATA = 3'd0,
        A_STAT = 3'd1,
        A_CTRL = 3'd2,
        A_FMT  = 3'd3,
        A_DIVL = 3'd4,
        A_DIVH = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'd0,
        PAR_OFF2 = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } par_mode_e;

    // control register layout, msb first
    typedef struct packed {
        logic      ninth;
        par_mode_e par;
        logic      stop2;
        logic      dbl;
        logic      ie_done;
        logic      ie_empty;
        logic      tx_en;
    } ctrl_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic int char_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 5;
            3'd1:    return 6;
            3'd2:    return 7;
            3'd7:    return 9;
            default: return 8;
        endcase
    endfunction

    // lay out one frame, first bit on the line in bit 0
    function automatic frame_t build_frame(input logic [MAXDATA-1:0] d,
                                           input logic [2:0] code,
                                           input par_mode_e par,
                                           input logic stop2);
        frame_t f;
        int     n;
        int     pos;
        logic   p;
        n       = char_bits(code);
        f.bits  = '1;
        f.bits[0] = 1'b0;
        p       = 1'b0;
        for (int i = 0; i < MAXDATA; i++) begin
            if (i < n) begin
                f.bits[1+i] = d[i];
                p = p ^ d[i];
            end
        end
        pos = 1 + n;
        if (par == PAR_EVEN) begin
            f.bits[pos] = p;
            pos = pos + 1;
        end else if (par == PAR_ODD) begin
            f.bits[pos] = ~p;
            pos = pos + 1;
        end
        pos   = pos + 1 + int'(stop2);
        f.len = LEN_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/stx_baud.sv
module stx_baud
    import stx_pkg::*;
#(
    parameter int OS_NORMAL = 16,
    parameter int OS_DOUBLE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    input  logic             dbl,
    output logic             bit_end
);
    localparam int OS_W = $clog2(OS_NORMAL);

    logic [DIV_W-1:0] pre_cnt;
    logic [OS_W-1:0]  os_cnt;
    logic [OS_W-1:0]  os_top;
    logic             pre_tick;

    assign os_top   = dbl ? OS_W'(OS_DOUBLE - 1) : OS_W'(OS_NORMAL - 1);
    assign pre_tick = (pre_cnt == div);
    assign bit_end  = pre_tick && (os_cnt == os_top);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
            os_cnt  <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            os_cnt  <= (os_cnt >= os_top) ? '0 : os_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] wdata,
    input  logic       ninth,
    input  logic [2:0] code,
    input  par_mode_e  par,
    input  logic       stop2,
    input  logic       bit_end,
    output logic       txd,
    output logic       active,
    output logic       pending,
    output logic       frame_done,
    output logic       frame_start
);
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic [MAXDATA-1:0] hold;
    logic [MAXDATA-1:0] src;
    logic               last;
    frame_t             nf;

    assign last        = active && bit_end && (left == LEN_W'(1));
    assign frame_start = (!active && load) || (last && (pending || load));
    assign frame_done  = last && !pending && !load;
    assign src         = pending ? hold : {ninth, wdata};

    always_comb begin
        nf = build_frame(src, code, par, stop2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            txd    <= 1'b1;
            shreg  <= '1;
            left   <= '0;
        end else if (frame_start) begin
            active <= 1'b1;
            txd    <= nf.bits[0];
            shreg  <= nf.bits >> 1;
            left   <= nf.len;
        end else if (active && bit_end) begin
            if (left == LEN_W'(1)) begin
                active <= 1'b0;
                txd    <= 1'b1;
            end else begin
                txd   <= shreg[0];
                shreg <= shreg >> 1;
                left  <= left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            hold    <= '0;
        end else if (load && active && !(last && !pending)) begin
            hold    <= {ninth, wdata};
            pending <= 1'b1;
        end else if (last && pending) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/stx_regs.sv
module stx_regs
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              frame_done,
    input  logic              busy,
    output logic [7:0]        rdata,
    output ctrl_t             ctrl,
    output logic [2:0]        code,
    output logic [DIV_W-1:0]  div,
    output logic              div_wr,
    output logic              data_ld,
    output logic              dre,
    output logic              tc
);
    reg_addr_e  a;
    logic [7:0] data_q;
    logic       ie_rise;
    logic       tc_clr;
    logic       ends_ok;

    assign a       = reg_addr_e'(addr);
    assign data_ld = we && (a == A_DATA);
    assign div_wr  = we && ((a == A_DIVL) || (a == A_DIVH));
    assign ie_rise = we && (a == A_CTRL) && wdata[1] && !ctrl.ie_empty;
    assign tc_clr  = we && (a == A_STAT) && wdata[1];
    assign ends_ok = frame_done && ctrl.tx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            code   <= 3'd3;
            div    <= '0;
            data_q <= '0;
        end else if (we) begin
            case (a)
                A_DATA:  data_q     <= wdata;
                A_CTRL:  ctrl       <= ctrl_t'(wdata);
                A_FMT:   code       <= wdata[2:0];
                A_DIVL:  div[7:0]   <= wdata;
                A_DIVH:  div[15:8]  <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dre <= 1'b1;
            tc  <= 1'b0;
        end else begin
            if (data_ld)
                dre <= 1'b0;
            else if (ends_ok || (ie_rise && !busy))
                dre <= 1'b1;

            if (ends_ok)
                tc <= 1'b1;
            else if (tc_clr)
                tc <= 1'b0;
        end
    end

    always_comb begin
        case (a)
            A_DATA:  rdata = data_q;
            A_STAT:  rdata = {6'b0, tc, dre};
            A_CTRL:  rdata = ctrl;
            A_FMT:   rdata = {5'b0, code};
            A_DIVL:  rdata = div[7:0];
            A_DIVH:  rdata = div[15:8];
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
    import stx_pkg::*;
#(
    parameter int OS_NORMAL = 16,
    parameter int OS_DOUBLE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              txd,
    output logic              irq_empty,
    output logic              irq_done
);
    ctrl_t            ctrl_q;
    logic [2:0]       code_q;
    logic [DIV_W-1:0] div_q;
    logic             div_wr;
    logic             data_ld;
    logic             dre_flag;
    logic             tc_flag;
    logic             sh_active;
    logic             sh_pending;
    logic             sh_done;
    logic             sh_start;
    logic             bit_end;
    logic             ie_empty_w;
    logic             tx_en_w;

    assign ie_empty_w = ctrl_q.ie_empty;
    assign tx_en_w    = ctrl_q.tx_en;
    assign irq_empty  = dre_flag && ctrl_q.ie_empty;
    assign irq_done   = tc_flag && ctrl_q.ie_done;

    stx_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .frame_done (sh_done),
        .busy       (sh_active || sh_pending),
        .rdata      (bus_rdata),
        .ctrl       (ctrl_q),
        .code       (code_q),
        .div        (div_q),
        .div_wr     (div_wr),
        .data_ld    (data_ld),
        .dre        (dre_flag),
        .tc         (tc_flag)
    );

    stx_baud #(
        .OS_NORMAL (OS_NORMAL),
        .OS_DOUBLE (OS_DOUBLE)
    ) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (sh_start || div_wr),
        .div     (div_q),
        .dbl     (ctrl_q.dbl),
        .bit_end (bit_end)
    );

    stx_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .load        (data_ld),
        .wdata       (bus_wdata),
        .ninth       (ctrl_q.ninth),
        .code        (code_q),
        .par         (ctrl_q.par),
        .stop2       (ctrl_q.stop2),
        .bit_end     (bit_end),
        .txd         (txd),
        .active      (sh_active),
        .pending     (sh_pending),
        .frame_done  (sh_done),
        .frame_start (sh_start)
    );
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic       wr_bit1,
    input logic       txd,
    input logic       irq_empty,
    input logic       dre,
    input logic       tc,
    input logic       ie_empty,
    input logic       tx_en,
    input logic       active,
    input logic       pending,
    input logic       frame_done
);
    AST_DATA_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd0) |=> !dre);  // R7

    AST_END_SETS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (frame_done && tx_en) |=> (dre && tc));  // R7

    AST_TC_WRITE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd1 && wr_bit1 && !frame_done) |=> !tc);  // R9

    AST_EMPTY_KICK: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd2 && wr_bit1 && !ie_empty && !active && !pending) |=> irq_empty);  // R10

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !active |-> txd);  // R3

    AST_HOLD_ONLY_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        pending |-> active);  // R8
endmodule

bind serial_tx_unit stx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wr_bit1    (bus_wdata[1]),
    .txd        (txd),
    .irq_empty  (irq_empty),
    .dre        (dre_flag),
    .tc         (tc_flag),
    .ie_empty   (ie_empty_w),
    .tx_en      (tx_en_w),
    .active     (sh_active),
    .pending    (sh_pending),
    .frame_done (sh_done)
);

// File: tb/serial_tx_unit_tb.sv
`timescale 1ns/1ps
module serial_tx_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       txd;
    logic       irq_empty;
    logic       irq_done;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_tx_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .txd       (txd),
        .irq_empty (irq_empty),
        .irq_done  (irq_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, output int e);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        e = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic setup(input logic [7:0] ctrl, input logic [2:0] code, input logic [15:0] div);
        int e;
        bus_write(3'd4, div[7:0], e);
        bus_write(3'd5, div[15:8], e);
        bus_write(3'd3, {5'b0, code}, e);
        bus_write(3'd2, ctrl, e);
    endtask

    function automatic logic exp_bit(input logic [8:0] d, input int nb, input int pm, input int k);
        int ones = 0;
        if (k == 0) return 1'b0;
        if (k <= nb) return d[k-1];
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        if (pm >= 2 && k == nb + 1) return (pm == 2) ? logic'(ones % 2) : logic'(1 - ones % 2);
        return 1'b1;
    endfunction

    function automatic int frame_len(input int nb, input int pm, input int st2);
        return 1 + nb + ((pm >= 2) ? 1 : 0) + 1 + st2;
    endfunction

    // sends one byte and checks every bit plus the flags at the frame boundary
    task automatic send_frame(input logic [7:0] d, input logic n9, input int nb, input int pm,
                              input int st2, input int bp, input bit en, input string req);
        int e0;
        int len;
        logic [7:0] v;
        len = frame_len(nb, pm, st2);
        bus_write(3'd0, d, e0);
        for (int k = 0; k < len; k++) begin
            wait_until(e0 + k * bp + bp / 2);
            chk({req, " bit"}, txd, exp_bit({n9, d}, nb, pm, k));
        end
        wait_until(e0 + len * bp - 1);
        rd(3'd1, v);
        chk("R7 empty still clear before frame end", v[0], 1'b0);
        wait_until(e0 + len * bp);
        rd(3'd1, v);
        chk("R7 flags at frame end", v[1:0], en ? 2'b11 : 2'b00);
        chk("R3 line idle after frame", txd, 1'b1);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd1, v);
        chk("R1 status after reset", v, 8'h01);
        chk("R1 line high after reset", txd, 1'b1);
        chk("R1 irq_empty low", irq_empty, 1'b0);
        chk("R1 irq_done low", irq_done, 1'b0);
    endtask

    task automatic t_basic;
        setup(8'h09, 3'd3, 16'd0);
        send_frame(8'hA5, 1'b0, 8, 0, 0, 8, 1'b1, "R3 8N1 A5");
        send_frame(8'h3C, 1'b0, 8, 0, 0, 8, 1'b1, "R3 8N1 3C");
    endtask

    task automatic t_tc_clear;
        int e;
        logic [7:0] v;
        bus_write(3'd1, 8'hFD, e);
        rd(3'd1, v);
        chk("R9 write with bit1=0 keeps flags", v, 8'h03);
        bus_write(3'd1, 8'h02, e);
        rd(3'd1, v);
        chk("R9 write 1 clears complete only", v, 8'h01);
    endtask

    task automatic t_formats;
        setup(8'h59, 3'd0, 16'd0);
        send_frame(8'h13, 1'b0, 5, 2, 1, 8, 1'b1, "R4 R5 R6 5E2");
        setup(8'hE9, 3'd7, 16'd0);
        send_frame(8'h0F, 1'b1, 9, 3, 0, 8, 1'b1, "R4 R5 9O1 ninth=1");
        setup(8'h29, 3'd5, 16'd0);
        send_frame(8'h81, 1'b0, 8, 1, 0, 8, 1'b1, "R4 R5 reserved code and mode 01");
        setup(8'h49, 3'd1, 16'd0);
        send_frame(8'h2A, 1'b0, 6, 2, 0, 8, 1'b1, "R4 R5 6E1");
    endtask

    task automatic t_rate;
        int e0;
        setup(8'h01, 3'd3, 16'd1);
        bus_write(3'd0, 8'hFF, e0);
        wait_until(e0 + 31);
        chk("R2 start bit still low at 31 (D=1 normal)", txd, 1'b0);
        wait_until(e0 + 32);
        chk("R2 data bit at 32 (D=1 normal)", txd, 1'b1);
        wait_until(e0 + 320);
        setup(8'h09, 3'd3, 16'd2);
        bus_write(3'd0, 8'hFF, e0);
        wait_until(e0 + 23);
        chk("R2 start bit still low at 23 (D=2 double)", txd, 1'b0);
        wait_until(e0 + 24);
        chk("R2 data bit at 24 (D=2 double)", txd, 1'b1);
        wait_until(e0 + 240);
    endtask

    task automatic t_back_to_back;
        int e0;
        int e1;
        int la;
        logic [7:0] v;
        setup(8'h09, 3'd3, 16'd0);
        bus_write(3'd1, 8'h02, e1);
        la = frame_len(8, 0, 0);
        bus_write(3'd0, 8'h5A, e0);
        wait_until(e0 + 8);
        bus_write(3'd0, 8'hC3, e1);
        rd(3'd1, v);
        chk("R8 empty clear while byte waits", v[0], 1'b0);
        for (int k = 2; k < la; k++) begin
            wait_until(e0 + k * 8 + 4);
            chk("R8 first frame bit", txd, exp_bit({1'b0, 8'h5A}, 8, 0, k));
        end
        wait_until(e0 + la * 8);
        rd(3'd1, v);
        chk("R8 no flags between chained frames", v[1:0], 2'b00);
        for (int k = 0; k < la; k++) begin
            wait_until(e0 + (la + k) * 8 + 4);
            chk("R8 second frame bit", txd, exp_bit({1'b0, 8'hC3}, 8, 0, k));
        end
        wait_until(e0 + 2 * la * 8);
        rd(3'd1, v);
        chk("R8 flags after last frame", v[1:0], 2'b11);
    endtask

    task automatic t_irq;
        int e;
        int e0;
        logic [7:0] v;
        bus_write(3'd2, 8'h0D, e);
        chk("R11 irq_done follows complete flag", irq_done, 1'b1);
        chk("R11 irq_empty off while disabled", irq_empty, 1'b0);
        bus_write(3'd1, 8'h02, e);
        chk("R11 irq_done drops after clear", irq_done, 1'b0);
        bus_write(3'd2, 8'h08, e);
        send_frame(8'h55, 1'b0, 8, 0, 0, 8, 1'b0, "R7 disabled frame");
        bus_write(3'd2, 8'h0A, e);
        chk("R10 enable while idle raises irq_empty", irq_empty, 1'b1);
        rd(3'd1, v);
        chk("R10 empty flag set by enable", v, 8'h01);
        bus_write(3'd2, 8'h09, e);
        bus_write(3'd0, 8'h00, e0);
        wait_until(e0 + 8);
        bus_write(3'd2, 8'h0B, e);
        chk("R10 enable during frame does not raise", irq_empty, 1'b0);
        wait_until(e0 + 80);
        chk("R11 irq_empty after frame end", irq_empty, 1'b1);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_tc_clear();
        t_formats();
        t_rate();
        t_back_to_back();
        t_irq();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule